// File: doc/BRIEF.md
# Scalable Watchdog Timer with Event Reload

This block is a watchdog for a configuration-space logical device. Software programs an 8-bit timeout count. The count drops by one on every timebase tick. A tick is one unit or sixty units, chosen by a control bit. The design treats a unit as one second. A prescaler turns the core clock into these units, and its cycle count is a parameter, so a bench can use very short seconds. When the count reaches zero the watchdog has expired. It then sets a sticky status flag and emits a one-cycle interrupt pulse. The pulse goes with a 4-bit interrupt-line number chosen by software. A keyboard-reset pulse can also be enabled.

Three 8-bit registers control the block. They are reached through a simple write strobe, an address and a combinational read-back. Software writes the count register to arm, reload or disable the timer. Mouse and keyboard interrupt activity can optionally reload the timer from the last value software wrote. A self-clearing force bit expires the watchdog at once. An external keyboard-controller line can also expire it at once, when enabled.

Top module: `tick_watchdog`

## Requirements
- R1: After reset every register reads 0x00 and the interrupt pulse, the keyboard-reset pulse and the line number are all 0. Unmapped addresses always read 0x00.
- R2: Writing a non-zero value V to address 0xF6 arms the timer. Reading 0xF6 returns the live count, which reads V right after the write. The first decrement comes one full tick after the write, because the write restarts the prescaler. Later decrements come one tick apart.
- R3: Writing 0 to 0xF6 disables the timer. The count then stays 0 and no expiry occurs until a non-zero value is written.
- R4: Address 0xF5 bit 3 selects the tick unit. 0 gives one unit of TICK_CYCLES clocks per decrement, and 1 gives MINUTE_TICKS units per decrement. Bits 3:1 read back as written, and the other bits read 0.
- R5: When a tick meets a count of 1, the count goes to 0 and stays there. In the next cycle, 0xF7 bit 4 (the fired flag) reads 1 and irq_pulse is high for one cycle. irq_line always shows 0xF7 bits 3:0.
- R6: kbd_rst_pulse goes high together with irq_pulse only when 0xF5 bit 1 is set.
- R7: 0xF7 bit 7 enables reload on mouse_evt, and bit 6 enables reload on kbd_evt. An enabled event while the count is non-zero restores the last value written to 0xF6 and restarts the prescaler. A disabled event has no effect on the count.
- R8: Writing 0xF7 with bit 5 set expires the watchdog at once. The count becomes 0, the fired flag is set and irq_pulse follows in the next cycle. Bit 5 always reads 0.
- R9: A rising edge on kbc_force expires the watchdog as in R8 when 0xF5 bit 2 is set. When that bit is clear, the edge has no effect.
- R10: The fired flag stays set until 0xF7 is written with bit 4 at 0. Writing bit 4 as 1 never sets the flag. An expiry in the same cycle as a clear leaves the flag set.
- R11: When events meet in one cycle, a forced expiry wins over a write to 0xF6. A write to 0xF6 wins over an event reload, and an event reload wins over a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address (0xF5, 0xF6, 0xF7) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Combinational read data for cfg_addr |
| mouse_evt | input | 1 | Mouse interrupt activity |
| kbd_evt | input | 1 | Keyboard interrupt activity |
| kbc_force | input | 1 | Keyboard-controller force-expiry line |
| irq_pulse | output | 1 | One-cycle expiry interrupt |
| irq_line | output | 4 | Selected interrupt line number |
| kbd_rst_pulse | output | 1 | One-cycle keyboard-reset pulse on expiry |

## Verification
A wrong prescaler phase or a missed restart shows up in the 0xF6 read-back. It appears one clock after the first tick boundary that is off, well before any expiry. A wrong count, reload value or priority choice shows up on the 0xF6 read or on irq_pulse within one cycle of the faulty update. A fired flag that is not sticky, or is set wrongly, is visible on the 0xF7 read at once. The reference model compares every output and the read-back on every cycle, so a bad state is reported in the first cycle it can be seen.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int REG_W = 8;
    localparam logic [REG_W-1:0] ADDR_CTL = 8'hF5;
    localparam logic [REG_W-1:0] ADDR_CNT = 8'hF6;
    localparam logic [REG_W-1:0] ADDR_SRC = 8'hF7;

    typedef struct packed {
        logic             scale;
        logic             p20_en;
        logic             kbrst_en;
        logic             mouse_en;
        logic             kbd_en;
        logic             fired;
        logic [3:0]       irq_sel;
        logic [REG_W-1:0] cnt;
        logic [REG_W-1:0] reload;
        logic             p20_prev;
        logic             irq;
        logic             kbrst;
    } wdt_state_t;
endpackage

// File: rtl/wdt_tickgen.sv
module wdt_tickgen #(
    parameter int TICK_CYCLES  = 32768,
    parameter int MINUTE_TICKS = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic long_unit,
    output logic tick
);
    localparam int PW = $clog2(TICK_CYCLES + 1);
    localparam int MW = $clog2(MINUTE_TICKS + 1);

    logic [PW-1:0] pre_q, pre_d;
    logic [MW-1:0] min_q, min_d;
    logic          wrap, min_last;

    assign wrap     = (pre_q == PW'(TICK_CYCLES - 1));
    assign min_last = (min_q == MW'(MINUTE_TICKS - 1));
    assign tick     = wrap && (!long_unit || min_last);

    always_comb begin
        pre_d = pre_q;
        min_d = min_q;
        if (restart) begin
            pre_d = '0;
            min_d = '0;
        end else if (wrap) begin
            pre_d = '0;
            min_d = min_last ? '0 : min_q + MW'(1);
        end else begin
            pre_d = pre_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            min_q <= '0;
        end else begin
            pre_q <= pre_d;
            min_q <= min_d;
        end
    end
endmodule

// File: rtl/wdt_rdmux.sv
module wdt_rdmux
    import wdt_pkg::*;
(
    input  wdt_state_t       st,
    input  logic [REG_W-1:0] addr,
    output logic [REG_W-1:0] rdata
);
    always_comb begin
        unique case (addr)
            ADDR_CTL: rdata = {4'b0, st.scale, st.p20_en, st.kbrst_en, 1'b0};
            ADDR_CNT: rdata = st.cnt;
            ADDR_SRC: rdata = {st.mouse_en, st.kbd_en, 1'b0, st.fired, st.irq_sel};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
    import wdt_pkg::*;
#(
    parameter int TICK_CYCLES  = 32768,
    parameter int MINUTE_TICKS = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [REG_W-1:0] cfg_addr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             mouse_evt,
    input  logic             kbd_evt,
    input  logic             kbc_force,
    output logic             irq_pulse,
    output logic [3:0]       irq_line,
    output logic             kbd_rst_pulse
);
    wdt_state_t q, d;
    logic wr_ctl, wr_cnt, wr_src;
    logic p20_rise, force_now, evt_hit, reload_take, expire, timeout, restart, tick;

    wdt_tickgen #(.TICK_CYCLES(TICK_CYCLES), .MINUTE_TICKS(MINUTE_TICKS)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(restart), .long_unit(q.scale), .tick(tick)
    );

    wdt_rdmux u_rd (.st(q), .addr(cfg_addr), .rdata(cfg_rdata));

    always_comb begin
        wr_ctl      = cfg_wr && (cfg_addr == ADDR_CTL);
        wr_cnt      = cfg_wr && (cfg_addr == ADDR_CNT);
        wr_src      = cfg_wr && (cfg_addr == ADDR_SRC);
        p20_rise    = q.p20_en && kbc_force && !q.p20_prev;
        force_now   = p20_rise || (wr_src && cfg_wdata[5]);
        evt_hit     = (q.mouse_en && mouse_evt) || (q.kbd_en && kbd_evt);
        reload_take = !force_now && !wr_cnt && (q.cnt != '0) && evt_hit;
        expire      = !force_now && !wr_cnt && !reload_take && tick
                      && (q.cnt == REG_W'(1));
        timeout     = force_now || expire;
        restart     = wr_cnt || reload_take;

        d          = q;
        d.p20_prev = kbc_force;
        if (wr_ctl) begin
            d.scale    = cfg_wdata[3];
            d.p20_en   = cfg_wdata[2];
            d.kbrst_en = cfg_wdata[1];
        end
        if (wr_src) begin
            d.mouse_en = cfg_wdata[7];
            d.kbd_en   = cfg_wdata[6];
            d.irq_sel  = cfg_wdata[3:0];
            d.fired    = q.fired && cfg_wdata[4];
        end
        if (wr_cnt) d.reload = cfg_wdata;

        if (force_now)                   d.cnt = '0;
        else if (wr_cnt)                 d.cnt = cfg_wdata;
        else if (reload_take)            d.cnt = q.reload;
        else if (tick && q.cnt != '0)    d.cnt = q.cnt - REG_W'(1);

        if (timeout) d.fired = 1'b1;
        d.irq   = timeout;
        d.kbrst = timeout && q.kbrst_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign irq_pulse     = q.irq;
    assign kbd_rst_pulse = q.kbrst;
    assign irq_line      = q.irq_sel;
endmodule

// File: rtl/wdt_checks.sv
module wdt_checks
    import wdt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [REG_W-1:0] cfg_addr,
    input logic             mouse_evt,
    input logic             kbd_evt,
    input logic             kbc_force,
    input logic             irq_pulse,
    input logic             kbd_rst_pulse,
    input logic [REG_W-1:0] cnt,
    input logic             fired
);
    a_r6_kbrst_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_rst_pulse |-> irq_pulse);

    a_r5_fired_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> fired);

    a_r3_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !(cfg_wr && cfg_addr == ADDR_CNT)) |=> (cnt == '0));

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && !cfg_wr && !mouse_evt && !kbd_evt && !kbc_force)
        |=> (cnt == $past(cnt) || cnt == $past(cnt) - REG_W'(1)));

    a_r5_expiry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == REG_W'(1) && !cfg_wr && !mouse_evt && !kbd_evt)
        |=> (irq_pulse == (cnt == '0)));
endmodule

bind tick_watchdog wdt_checks u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .mouse_evt(mouse_evt), .kbd_evt(kbd_evt), .kbc_force(kbc_force),
    .irq_pulse(irq_pulse), .kbd_rst_pulse(kbd_rst_pulse),
    .cnt(q.cnt), .fired(q.fired)
);

// File: tb/tick_watchdog_bench.sv
module tick_watchdog_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TCYC = 4;
    localparam int MTK  = 3;

    logic       clk = 0, rst_n = 0;
    logic       cfg_wr = 0, mouse_evt = 0, kbd_evt = 0, kbc_force = 0;
    logic [7:0] cfg_addr = 0, cfg_wdata = 0, cfg_rdata;
    logic       irq_pulse, kbd_rst_pulse;
    logic [3:0] irq_line;

    int checks = 0, errors = 0, cycles = 0, kbrst_seen = 0, irq_seen = 0;

    tick_watchdog #(.TICK_CYCLES(TCYC), .MINUTE_TICKS(MTK)) u_tick_watchdog (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mouse_evt(mouse_evt),
        .kbd_evt(kbd_evt), .kbc_force(kbc_force), .irq_pulse(irq_pulse),
        .irq_line(irq_line), .kbd_rst_pulse(kbd_rst_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    int  m_cnt = 0, m_rel = 0, m_sel = 0, m_pre = 0, m_min = 0;
    bit  m_scale = 0, m_p20 = 0, m_kbr = 0, m_mouse = 0, m_kbd = 0, m_fired = 0;
    bit  m_prev = 0, m_irq = 0, m_krst = 0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_read(int a);
        if (a == 'hF5) return (m_scale << 3) | (m_p20 << 2) | (m_kbr << 1);
        if (a == 'hF6) return m_cnt;
        if (a == 'hF7) return (m_mouse << 7) | (m_kbd << 6) | (m_fired << 4) | m_sel;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_rel = 0; m_sel = 0; m_pre = 0; m_min = 0;
            m_scale = 0; m_p20 = 0; m_kbr = 0; m_mouse = 0; m_kbd = 0;
            m_fired = 0; m_prev = 0; m_irq = 0; m_krst = 0;
        end else begin
            bit tick_now, frc, wcnt, rel, exp_now, restart;
            bit o_scale, o_p20, o_kbr, o_mouse, o_kbd, o_fired;
            int o_cnt;
            cycles++;
            o_scale = m_scale; o_p20 = m_p20; o_kbr = m_kbr; o_mouse = m_mouse;
            o_kbd = m_kbd; o_fired = m_fired; o_cnt = m_cnt;
            tick_now = (m_pre == TCYC - 1) && (!o_scale || m_min == MTK - 1);
            wcnt = cfg_wr && cfg_addr == 'hF6;
            frc  = (o_p20 && kbc_force && !m_prev) ||
                   (cfg_wr && cfg_addr == 'hF7 && cfg_wdata[5]);
            rel  = !frc && !wcnt && o_cnt != 0 &&
                   ((o_mouse && mouse_evt) || (o_kbd && kbd_evt));
            exp_now = !frc && !wcnt && !rel && tick_now && o_cnt == 1;
            restart = wcnt || rel;
            if (restart) begin m_pre = 0; m_min = 0; end
            else if (m_pre == TCYC - 1) begin
                m_pre = 0; m_min = (m_min == MTK - 1) ? 0 : m_min + 1;
            end else m_pre++;
            if (cfg_wr && cfg_addr == 'hF5) begin
                m_scale = cfg_wdata[3]; m_p20 = cfg_wdata[2]; m_kbr = cfg_wdata[1];
            end
            if (cfg_wr && cfg_addr == 'hF7) begin
                m_mouse = cfg_wdata[7]; m_kbd = cfg_wdata[6]; m_sel = cfg_wdata[3:0];
                m_fired = o_fired && cfg_wdata[4];
            end
            if (wcnt) m_rel = cfg_wdata;
            if (frc) m_cnt = 0;
            else if (wcnt) m_cnt = cfg_wdata;
            else if (rel) m_cnt = m_rel;
            else if (tick_now && o_cnt != 0) m_cnt = o_cnt - 1;
            if (frc || exp_now) m_fired = 1;
            m_irq  = frc || exp_now;
            m_krst = (frc || exp_now) && o_kbr;
            m_prev = kbc_force;
        end
    end

    // every-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            string t;
            t = (cfg_addr == 8'hF6) ? "R2" : (cfg_addr == 8'hF7) ? "R10" :
                (cfg_addr == 8'hF5) ? "R4" : "R1";
            check(t, cfg_rdata, exp_read(cfg_addr));
            check("R5", irq_pulse, m_irq);
            check("R5", irq_line, m_sel);
            check("R6", kbd_rst_pulse, m_krst);
            if (irq_pulse) irq_seen++;
            if (kbd_rst_pulse) kbrst_seen++;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(posedge clk); #1;
        cfg_wr = 1; cfg_addr = a; cfg_wdata = v;
        @(posedge clk); #1;
        cfg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input int exp, input string tag);
        @(posedge clk); #1;
        cfg_addr = a;
        @(negedge clk);
        check(tag, cfg_rdata, exp);
    endtask

    task automatic pulse_evt(input bit mouse);
        @(posedge clk); #1;
        if (mouse) mouse_evt = 1; else kbd_evt = 1;
        @(posedge clk); #1;
        mouse_evt = 0; kbd_evt = 0;
    endtask

    initial begin
        int seen;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", irq_pulse, 0); check("R1", kbd_rst_pulse, 0); check("R1", irq_line, 0);
        rst_n = 1;
        rd(8'hF5, 0, "R1"); rd(8'hF6, 0, "R1"); rd(8'hF7, 0, "R1"); rd(8'h10, 0, "R1");
        // R2 / R5 plain countdown to expiry
        wr(8'hF7, 8'h05);
        wr(8'hF6, 8'h03);
        rd(8'hF6, 3, "R2");
        repeat (20) @(posedge clk);
        rd(8'hF6, 0, "R5");
        rd(8'hF7, 8'h15, "R5");
        check("R5", irq_line, 5);
        check("R6", kbrst_seen, 0);
        // R10 sticky flag
        wr(8'hF7, 8'h15); rd(8'hF7, 8'h15, "R10");
        wr(8'hF7, 8'h05); rd(8'hF7, 8'h05, "R10");
        wr(8'hF7, 8'h15); rd(8'hF7, 8'h05, "R10");
        // R4 long unit, R6 keyboard reset
        wr(8'hF5, 8'h0A);
        rd(8'hF5, 8'h0A, "R4");
        wr(8'hF6, 8'h02);
        repeat (6) @(posedge clk);
        rd(8'hF6, 2, "R4");
        repeat (30) @(posedge clk);
        rd(8'hF6, 0, "R4");
        check("R6", kbrst_seen, 1);
        // R7 mouse reload
        wr(8'hF5, 8'h00);
        wr(8'hF7, 8'h85);
        wr(8'hF6, 8'h05);
        repeat (6) @(posedge clk);
        pulse_evt(1);
        rd(8'hF6, 5, "R7");
        // R7 disabled keyboard event ignored
        wr(8'hF6, 8'h03);
        repeat (5) @(posedge clk);
        pulse_evt(0);
        rd(8'hF6, 1, "R7");
        // R8 forced expiry via register
        wr(8'hF7, 8'hA5);
        rd(8'hF7, 8'h95, "R8");
        rd(8'hF6, 0, "R8");
        // R9 keyboard-controller line
        wr(8'hF7, 8'h05);
        seen = irq_seen;
        @(posedge clk); #1; kbc_force = 1;
        repeat (3) @(posedge clk);
        rd(8'hF7, 8'h05, "R9");
        check("R9", irq_seen, seen);
        #1; kbc_force = 0;
        wr(8'hF5, 8'h04);
        @(posedge clk); #1; kbc_force = 1;
        repeat (2) @(posedge clk);
        rd(8'hF7, 8'h15, "R9");
        #1; kbc_force = 0;
        // R3 disable
        wr(8'hF7, 8'h05);
        wr(8'hF6, 8'h02);
        wr(8'hF6, 8'h00);
        seen = irq_seen;
        repeat (40) @(posedge clk);
        rd(8'hF6, 0, "R3");
        rd(8'hF7, 8'h05, "R3");
        check("R3", irq_seen, seen);
        // R11 force beats count write
        @(posedge clk); #1;
        cfg_wr = 1; cfg_addr = 8'hF6; cfg_wdata = 8'h09; kbc_force = 1;
        @(posedge clk); #1;
        cfg_wr = 0;
        rd(8'hF6, 0, "R11");
        rd(8'hF7, 8'h15, "R11");
        #1; kbc_force = 0;
        // R11 count write beats event reload
        wr(8'hF7, 8'h85);
        wr(8'hF6, 8'h04);
        @(posedge clk); #1;
        cfg_wr = 1; cfg_addr = 8'hF6; cfg_wdata = 8'h07; mouse_evt = 1;
        @(posedge clk); #1;
        cfg_wr = 0; mouse_evt = 0;
        rd(8'hF6, 7, "R11");
        repeat (5) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule